// File: doc/BRIEF.md
# FIFO Status, Interrupt and DMA Request Unit

This block sits beside the transmit and receive queues of a serial controller. It holds both queues (32 entries each by default). It watches what is pushed into them and popped out, and from this it derives three things: a status word, a set of interrupt sources, and one DMA request line per direction. The host loads the queue for transmission and drains the receive queue. The serial engine does the opposite on each queue and also reports whether it is busy.

Software configures the block through a small register port. Through that port it sets the interrupt thresholds, the DMA thresholds, the interrupt mask and the DMA enables. It reads back the queue levels, the status word and the raw and masked interrupt vectors. It also writes a clear register that drops sticky error flags. Overflow and underflow events are kept until they are cleared. The threshold sources follow the queue levels directly and are not latched.

Register addresses (reg_addr): 0 TX level, 1 RX level, 2 TX interrupt threshold, 3 RX interrupt threshold, 4 interrupt mask, 5 clear (write only, reads 0), 6 DMA enable, 7 TX DMA threshold, 8 RX DMA threshold, 9 status, 10 raw interrupts, 11 masked interrupts. Any other address reads 0. Register reads are combinational. Register writes take effect at the next clock edge.

Top module: `fifo_status_unit`

## Requirements
- R1: Each queue returns its entries in the order they were pushed. It holds up to 32 entries. Its occupancy can be read at address 0 (TX) or 1 (RX) and changes on the clock edge of the push or pop.
- R2: The status word at address 9 has these bits: bit 0 = engine_busy, bit 1 = TX full, bit 2 = TX empty, bit 3 = RX empty, bit 4 = RX full.
- R3: A push into a full queue is dropped and leaves the level unchanged. On TX this sets the sticky flag at raw interrupt bit 1. On RX it sets the sticky flag at raw interrupt bit 3.
- R4: A pop from an empty RX queue returns 0 on rx_rdata and sets the sticky flag at raw interrupt bit 2.
- R5: Writes to address 5 clear sticky flags. Bit 0 clears all of them, bit 1 clears RX underflow, bit 2 clears RX overflow and bit 3 clears TX overflow. An uncleared flag stays set.
- R6: Raw interrupt bit 0 is 1 exactly while the TX level is less than or equal to the TX interrupt threshold.
- R7: Raw interrupt bit 4 is 1 exactly while the RX level is at least the RX interrupt threshold plus one.
- R8: The masked vector at address 11 is the raw vector ANDed with the mask register. The irq output is 1 exactly when any masked bit is 1.
- R9: tx_dma_req is 1 exactly when DMA enable bit 1 is set and the TX level is at or below the TX DMA threshold.
- R10: rx_dma_req is 1 exactly when DMA enable bit 0 is set and the RX level is at least the RX DMA threshold plus one.
- R11: After reset both queues are empty. All thresholds, the mask and the DMA enables are 0, and no sticky flag is set. So the raw vector is 0x01, the status is 0x0C and irq, tx_dma_req and rx_dma_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| tx_push | input | 1 | Host writes one word into the TX queue |
| tx_wdata | input | DW | Word pushed into the TX queue |
| tx_pop | input | 1 | Engine takes the head of the TX queue |
| tx_rdata | output | DW | Head of the TX queue, 0 when empty |
| rx_push | input | 1 | Engine writes one received word |
| rx_wdata | input | DW | Word pushed into the RX queue |
| rx_pop | input | 1 | Host takes the head of the RX queue |
| rx_rdata | output | DW | Head of the RX queue, 0 when empty |
| engine_busy | input | 1 | Serial engine activity, shown in status bit 0 |
| irq | output | 1 | OR of the masked interrupt vector |
| tx_dma_req | output | 1 | TX direction DMA request |
| rx_dma_req | output | 1 | RX direction DMA request |

## Verification
The queue heads and the results of a register read are combinational, so they are due in the same cycle as their stimulus. The bench samples them 1 ns after setting the address or the pop strobe. Levels, sticky flags, interrupt sources, irq and DMA requests all follow from state that updates on the edge that takes the push, pop or register write. The bench therefore drives every stimulus on a falling edge and checks its effect at the next falling edge, which is exactly one register stage later. A vector table checks the threshold sources on both sides of each compare. Directed sequences cover the full queue, the empty queue, each clear bit, the mask and the DMA enables.

// File: rtl/fsu_pkg.sv
// Package: register map and bus width shared by the unit and its checker.
// Assumes a 4-bit word address; unlisted addresses read as zero.
package fsu_pkg;
    localparam int RW = 16;   // register data width
    localparam int AW = 4;    // register address width

    localparam logic [AW-1:0] A_TXLVL  = 4'd0;
    localparam logic [AW-1:0] A_RXLVL  = 4'd1;
    localparam logic [AW-1:0] A_TXTHR  = 4'd2;
    localparam logic [AW-1:0] A_RXTHR  = 4'd3;
    localparam logic [AW-1:0] A_MASK   = 4'd4;
    localparam logic [AW-1:0] A_CLR    = 4'd5;
    localparam logic [AW-1:0] A_DMAEN  = 4'd6;
    localparam logic [AW-1:0] A_TXDTHR = 4'd7;
    localparam logic [AW-1:0] A_RXDTHR = 4'd8;
    localparam logic [AW-1:0] A_STAT   = 4'd9;
    localparam logic [AW-1:0] A_RAW    = 4'd10;
    localparam logic [AW-1:0] A_MSKD   = 4'd11;

    localparam int NIRQ = 5;  // interrupt sources
endpackage

// File: rtl/fsu_fifo.sv
// Module: synchronous queue with first-word-fall-through head.
// A push into a full queue or a pop from an empty one does nothing to the
// contents and is reported on push_drop / pop_miss for one cycle.
// Assumes DEPTH >= 2. Head reads 0 when empty.
module fsu_fifo #(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty,
    output logic          push_drop,
    output logic          pop_miss
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full      = (level == LW'(DEPTH));
    assign empty     = (level == '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign push_drop = push && full;
    assign pop_miss  = pop && empty;
    assign rdata     = empty ? '0 : mem[rd_ptr];

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end
endmodule

// File: rtl/fsu_flags.sv
// Module: sticky error flags (TX overflow, RX underflow, RX overflow).
// A set event in the same cycle as a clear wins, so no event is lost.
// Assumes clr_bits is only meaningful when clr_we is high.
module fsu_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_txo,
    input  logic       set_rxu,
    input  logic       set_rxo,
    input  logic       clr_we,
    input  logic [3:0] clr_bits,
    output logic       txo,
    output logic       rxu,
    output logic       rxo
);
    logic clr_all, clr_rxu, clr_rxo, clr_txo;

    assign clr_all = clr_we && clr_bits[0];
    assign clr_rxu = clr_all || (clr_we && clr_bits[1]);
    assign clr_rxo = clr_all || (clr_we && clr_bits[2]);
    assign clr_txo = clr_all || (clr_we && clr_bits[3]);

    // Hold each flag until its clear bit, re-arm on a new event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txo <= 1'b0;
            rxu <= 1'b0;
            rxo <= 1'b0;
        end else begin
            txo <= set_txo || (txo && !clr_txo);
            rxu <= set_rxu || (rxu && !clr_rxu);
            rxo <= set_rxo || (rxo && !clr_rxo);
        end
    end
endmodule

// File: rtl/fsu_irq_dma.sv
// Module: combinational interrupt vector, interrupt line and DMA requests.
// Compares are done one bit wider than the threshold so "threshold + 1"
// never wraps. Assumes thresholds are RW bits and levels LW bits.
module fsu_irq_dma #(
    parameter int LW   = 6,
    parameter int RW   = 16,
    parameter int NIRQ = 5
) (
    input  logic [LW-1:0]   tx_level,
    input  logic [LW-1:0]   rx_level,
    input  logic [RW-1:0]   tx_thr,
    input  logic [RW-1:0]   rx_thr,
    input  logic [RW-1:0]   tx_dthr,
    input  logic [RW-1:0]   rx_dthr,
    input  logic            txo,
    input  logic            rxu,
    input  logic            rxo,
    input  logic [NIRQ-1:0] mask,
    input  logic [1:0]      dma_en,
    output logic [NIRQ-1:0] raw,
    output logic [NIRQ-1:0] masked,
    output logic            irq,
    output logic            tx_dma_req,
    output logic            rx_dma_req
);
    logic [RW:0] txl, rxl;

    assign txl = (RW+1)'(tx_level);
    assign rxl = (RW+1)'(rx_level);

    // Source vector: level-based threshold bits plus sticky flags.
    always_comb begin
        raw[0] = txl <= {1'b0, tx_thr};
        raw[1] = txo;
        raw[2] = rxu;
        raw[3] = rxo;
        raw[4] = rxl >= ({1'b0, rx_thr} + 1'b1);
    end

    assign masked     = raw & mask;
    assign irq        = |masked;
    assign tx_dma_req = dma_en[1] && (txl <= {1'b0, tx_dthr});
    assign rx_dma_req = dma_en[0] && (rxl >= ({1'b0, rx_dthr} + 1'b1));
endmodule

// File: rtl/fifo_status_unit.sv
// Module: top. Two queues, sticky flags, interrupt and DMA logic and the
// configuration/readback registers. Register reads are combinational.
// Assumes one register access per cycle and DEPTH < 2**16.
module fifo_status_unit
    import fsu_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_wdata,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_rdata,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_wdata,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_rdata,
    input  logic          engine_busy,
    output logic          irq,
    output logic          tx_dma_req,
    output logic          rx_dma_req
);
    localparam int LW = $clog2(DEPTH + 1);

    logic [LW-1:0]   tx_level, rx_level;
    logic            tx_full, tx_empty, rx_full, rx_empty;
    logic            tx_drop, tx_miss, rx_drop, rx_miss;
    logic            txo, rxu, rxo;
    logic [RW-1:0]   tx_thr, rx_thr, tx_dthr, rx_dthr;
    logic [NIRQ-1:0] mask, raw_irq, masked_irq;
    logic [1:0]      dma_en;
    logic [4:0]      status;

    fsu_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_wdata),
        .pop(tx_pop), .rdata(tx_rdata), .level(tx_level), .full(tx_full),
        .empty(tx_empty), .push_drop(tx_drop), .pop_miss(tx_miss)
    );

    fsu_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata),
        .pop(rx_pop), .rdata(rx_rdata), .level(rx_level), .full(rx_full),
        .empty(rx_empty), .push_drop(rx_drop), .pop_miss(rx_miss)
    );

    fsu_flags u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_txo(tx_drop), .set_rxu(rx_miss), .set_rxo(rx_drop),
        .clr_we(reg_we && reg_addr == A_CLR), .clr_bits(reg_wdata[3:0]),
        .txo(txo), .rxu(rxu), .rxo(rxo)
    );

    fsu_irq_dma #(.LW(LW), .RW(RW), .NIRQ(NIRQ)) u_evt (
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_thr(tx_thr), .rx_thr(rx_thr), .tx_dthr(tx_dthr), .rx_dthr(rx_dthr),
        .txo(txo), .rxu(rxu), .rxo(rxo), .mask(mask), .dma_en(dma_en),
        .raw(raw_irq), .masked(masked_irq), .irq(irq),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    assign status = {rx_full, rx_empty, tx_empty, tx_full, engine_busy};

    // Configuration registers written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr  <= '0;
            rx_thr  <= '0;
            tx_dthr <= '0;
            rx_dthr <= '0;
            mask    <= '0;
            dma_en  <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                A_TXTHR:  tx_thr  <= reg_wdata;
                A_RXTHR:  rx_thr  <= reg_wdata;
                A_TXDTHR: tx_dthr <= reg_wdata;
                A_RXDTHR: rx_dthr <= reg_wdata;
                A_MASK:   mask    <= reg_wdata[NIRQ-1:0];
                A_DMAEN:  dma_en  <= reg_wdata[1:0];
                default: ;
            endcase
        end
    end

    // Readback multiplexer.
    always_comb begin
        case (reg_addr)
            A_TXLVL:  reg_rdata = RW'(tx_level);
            A_RXLVL:  reg_rdata = RW'(rx_level);
            A_TXTHR:  reg_rdata = tx_thr;
            A_RXTHR:  reg_rdata = rx_thr;
            A_MASK:   reg_rdata = RW'(mask);
            A_DMAEN:  reg_rdata = RW'(dma_en);
            A_TXDTHR: reg_rdata = tx_dthr;
            A_RXDTHR: reg_rdata = rx_dthr;
            A_STAT:   reg_rdata = RW'(status);
            A_RAW:    reg_rdata = RW'(raw_irq);
            A_MSKD:   reg_rdata = RW'(masked_irq);
            default:  reg_rdata = '0;
        endcase
    end

    logic unused_tx_miss;
    assign unused_tx_miss = tx_miss;
endmodule

// File: rtl/fsu_checker.sv
// Module: property checker attached to every fifo_status_unit instance.
// Observes ports and internal state; drives nothing.
module fsu_checker #(
    parameter int LW    = 6,
    parameter int DEPTH = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tx_push,
    input logic          tx_pop,
    input logic          rx_pop,
    input logic          reg_we,
    input logic [3:0]    reg_addr,
    input logic [15:0]   reg_wdata,
    input logic [LW-1:0] tx_level,
    input logic [LW-1:0] rx_level,
    input logic          tx_full,
    input logic          rx_empty,
    input logic [4:0]    raw_irq,
    input logic [1:0]    dma_en,
    input logic          irq,
    input logic          tx_dma_req,
    input logic          rx_dma_req
);
    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LW'(DEPTH) && rx_level <= LW'(DEPTH));

    assert_drop_on_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push && tx_full && !tx_pop |=> tx_level == LW'(DEPTH) && raw_irq[1]);

    assert_underflow_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop && rx_empty |=> raw_irq[2]);

    assert_txo_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        raw_irq[1] && !(reg_we && reg_addr == 4'd5) |=> raw_irq[1]);

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> raw_irq != 5'd0);

    assert_txdma_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> dma_en[1]);

    assert_rxdma_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> dma_en[0] && rx_level != '0);

    logic unused_wdata;
    assign unused_wdata = ^reg_wdata;
endmodule

bind fifo_status_unit fsu_checker #(.LW(LW), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_push(tx_push), .tx_pop(tx_pop),
    .rx_pop(rx_pop), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tx_level(tx_level), .rx_level(rx_level),
    .tx_full(tx_full), .rx_empty(rx_empty), .raw_irq(raw_irq),
    .dma_en(dma_en), .irq(irq), .tx_dma_req(tx_dma_req),
    .rx_dma_req(rx_dma_req)
);

// File: tb/fifo_status_unit_test.sv
// Bench: vector table for threshold sources, then directed tests.
// Inputs change on falling edges; registered effects are checked one
// falling edge later, combinational reads 1 ns after the address/strobe.
module fifo_status_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [15:0] tx_wdata = 16'd0, rx_wdata = 16'd0;
    logic [15:0] tx_rdata, rx_rdata;
    logic        engine_busy = 1'b0;
    logic        irq, tx_dma_req, rx_dma_req;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    fifo_status_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_push(tx_push),
        .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
        .rx_rdata(rx_rdata), .engine_busy(engine_busy), .irq(irq),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
    );

    // {ntx[6], nrx[6], tx_thr[6], rx_thr[6], exp raw0, exp raw4}
    localparam logic [25:0] VEC [6] = '{
        {6'd0,  6'd0,  6'd0,  6'd0,  1'b1, 1'b0},
        {6'd1,  6'd1,  6'd0,  6'd0,  1'b0, 1'b1},
        {6'd4,  6'd3,  6'd4,  6'd3,  1'b1, 1'b0},
        {6'd5,  6'd4,  6'd4,  6'd3,  1'b0, 1'b1},
        {6'd32, 6'd32, 6'd31, 6'd31, 1'b0, 1'b1},
        {6'd10, 6'd9,  6'd16, 6'd9,  1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic push_tx(input logic [15:0] v);
        tx_push = 1'b1; tx_wdata = v;
        tick();
        tx_push = 1'b0;
    endtask

    task automatic push_rx(input logic [15:0] v);
        rx_push = 1'b1; rx_wdata = v;
        tick();
        rx_push = 1'b0;
    endtask

    task automatic pop_tx();
        tx_pop = 1'b1;
        tick();
        tx_pop = 1'b0;
    endtask

    task automatic pop_rx();
        rx_pop = 1'b1;
        tick();
        rx_pop = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R11 reset state
        rd(4'd0, d);  chk("R11 tx level", d, 16'd0);
        rd(4'd1, d);  chk("R11 rx level", d, 16'd0);
        rd(4'd9, d);  chk("R11 status", d, 16'h000C);
        rd(4'd10, d); chk("R11 raw", d, 16'h0001);
        rd(4'd11, d); chk("R11 masked", d, 16'h0000);
        chk("R11 irq", {15'd0, irq}, 16'd0);
        chk("R11 tx dma", {15'd0, tx_dma_req}, 16'd0);
        chk("R11 rx dma", {15'd0, rx_dma_req}, 16'd0);
        chk("R11 tx head", tx_rdata, 16'd0);

        // R2 busy bit
        engine_busy = 1'b1;
        rd(4'd9, d); chk("R2 busy", d, 16'h000D);
        engine_busy = 1'b0;

        // Table: R6 and R7 threshold sources, R1 levels and order
        for (int k = 0; k < 6; k++) begin
            int ntx, nrx;
            ntx = int'(VEC[k][25:20]);
            nrx = int'(VEC[k][19:14]);
            wr(4'd2, {10'd0, VEC[k][13:8]});
            wr(4'd3, {10'd0, VEC[k][7:2]});
            for (int i = 0; i < ntx; i++) push_tx(16'h0100 + 16'(i));
            for (int i = 0; i < nrx; i++) push_rx(16'h0200 + 16'(i));
            rd(4'd0, d);  chk("R1 tx level", d, 16'(ntx));
            rd(4'd1, d);  chk("R1 rx level", d, 16'(nrx));
            rd(4'd10, d);
            chk("R6 tx threshold source", {15'd0, d[0]}, {15'd0, VEC[k][1]});
            chk("R7 rx threshold source", {15'd0, d[4]}, {15'd0, VEC[k][0]});
            for (int i = 0; i < ntx; i++) begin
                chk("R1 tx order", tx_rdata, 16'h0100 + 16'(i));
                pop_tx();
            end
            for (int i = 0; i < nrx; i++) begin
                #1;
                chk("R1 rx order", rx_rdata, 16'h0200 + 16'(i));
                pop_rx();
            end
        end

        // R3 TX overflow: 33 pushes, last dropped
        for (int i = 0; i < 33; i++) push_tx(16'h0A00 + 16'(i));
        rd(4'd0, d);  chk("R3 tx level at full", d, 16'd32);
        rd(4'd9, d);  chk("R2 status tx full", d, 16'h000A);
        rd(4'd10, d); chk("R3 tx overflow flag", {15'd0, d[1]}, 16'd1);
        for (int i = 0; i < 32; i++) begin
            chk("R3 tx data kept", tx_rdata, 16'h0A00 + 16'(i));
            pop_tx();
        end
        chk("R3 dropped word absent", tx_rdata, 16'd0);
        rd(4'd10, d); chk("R5 tx overflow stays", {15'd0, d[1]}, 16'd1);
        wr(4'd5, 16'h0008);
        rd(4'd10, d); chk("R5 clear tx overflow", {15'd0, d[1]}, 16'd0);

        // R3 RX overflow, R2 rx full
        for (int i = 0; i < 33; i++) push_rx(16'h0B00 + 16'(i));
        rd(4'd1, d);  chk("R3 rx level at full", d, 16'd32);
        rd(4'd9, d);  chk("R2 status rx full", d, 16'h0014);
        rd(4'd10, d); chk("R3 rx overflow flag", {15'd0, d[3]}, 16'd1);
        for (int i = 0; i < 32; i++) pop_rx();

        // R4 underflow
        rx_pop = 1'b1;
        #1;
        chk("R4 empty pop data", rx_rdata, 16'd0);
        tick();
        rx_pop = 1'b0;
        rd(4'd10, d); chk("R4 underflow flag", {15'd0, d[2]}, 16'd1);
        rd(4'd1, d);  chk("R4 level stays zero", d, 16'd0);

        // R5 selective clear: bit 1 clears underflow only
        wr(4'd5, 16'h0002);
        rd(4'd10, d); chk("R5 clear underflow only", d & 16'h000C, 16'h0008);
        pop_rx();
        wr(4'd5, 16'h0001);
        rd(4'd10, d); chk("R5 clear all", d & 16'h000E, 16'h0000);

        // R8 mask and irq line
        pop_rx();
        wr(4'd4, 16'h0004);
        rd(4'd11, d); chk("R8 masked vector", d, 16'h0004);
        chk("R8 irq with unmasked source", {15'd0, irq}, 16'd1);
        wr(4'd4, 16'h0008);
        rd(4'd11, d); chk("R8 masked vector none", d, 16'h0000);
        chk("R8 irq masked off", {15'd0, irq}, 16'd0);
        wr(4'd5, 16'h0001);
        wr(4'd4, 16'h0000);

        // R9 TX DMA request
        wr(4'd7, 16'd3);
        chk("R9 disabled", {15'd0, tx_dma_req}, 16'd0);
        wr(4'd6, 16'h0002);
        chk("R9 enabled empty", {15'd0, tx_dma_req}, 16'd1);
        for (int i = 0; i < 3; i++) push_tx(16'(i));
        chk("R9 at threshold", {15'd0, tx_dma_req}, 16'd1);
        push_tx(16'd3);
        chk("R9 above threshold", {15'd0, tx_dma_req}, 16'd0);
        chk("R10 rx disabled", {15'd0, rx_dma_req}, 16'd0);
        for (int i = 0; i < 4; i++) pop_tx();

        // R10 RX DMA request
        wr(4'd8, 16'd1);
        wr(4'd6, 16'h0001);
        chk("R9 tx off when bit1 clear", {15'd0, tx_dma_req}, 16'd0);
        push_rx(16'd7);
        chk("R10 at threshold", {15'd0, rx_dma_req}, 16'd0);
        push_rx(16'd8);
        chk("R10 above threshold", {15'd0, rx_dma_req}, 16'd1);
        wr(4'd6, 16'h0002);
        chk("R10 disabled with level", {15'd0, rx_dma_req}, 16'd0);
        pop_rx();
        pop_rx();

        finish_run();
    end
endmodule